// File: doc/BRIEF.md
# Endpoint FIFO Access Handshake Controller

This block lets a microcontroller exchange packets with four USB endpoint buffers through one byte-wide register bus. It has one command/status byte and four data ports. Firmware selects an endpoint, chooses a direction and raises a request bit. After a programmable number of clock cycles the block reports that the buffer is ready. Firmware then moves bytes through the data port of that endpoint.

A transfer is not closed by a pop or push strobe. It is closed by flipping the direction bit while the request bit stays high. For a write session that flip commits the bytes as a transmit packet. For a read session it frees the received packet. The same byte also provides a forced flush, a sticky flag for SETUP packets and a flag for empty packets from the host.

The USB side is a simplified packet port. Received bytes arrive tagged with an endpoint and are closed by an end strobe. Committed packets are offered with their byte count, popped one byte at a time and then acknowledged.

Top module: `usb_ep_bridge`

## Requirements
- R1: Reset, and a pulse on `usb_rst`, leave the control byte (bus address 0) reading 0x00.
- R2: The control byte has this layout: bit0 request, bit1 direction (1 = firmware writes), bit2 flush, bits4:3 endpoint, bit5 setup flag, bit6 ready (read-only), bit7 empty-packet flag. Ready reads 0 until exactly SETTLE clock edges after the edge that sets the request bit.
- R3: In a read session (request raised while direction = 0), data port 4+e (e = selected endpoint) returns the received bytes in arrival order. Ready stays 0 once every byte has been read.
- R4: In a read session, setting the direction bit while the request bit is held, with the settle period elapsed, frees the endpoint. A following write session on it then reports ready.
- R5: In a write session (request raised while direction = 1), bytes written to port 4+e are stored in order. Ready is 0 once DEPTH bytes are held. Clearing the direction bit while the request bit is held, settled, offers the packet on the USB side with its length and its bytes in order.
- R6: Committing a write session with no bytes written offers a packet of length 0.
- R7: Setting flush together with the request bit empties the selected endpoint even though it is not ready.
- R8: The setup flag is set when a SETUP packet ends on the selected endpoint. It stays set until firmware writes 0 to bit5. Writing 1 to bit5 does not set it.
- R9: The empty-packet flag is set when a packet with no bytes ends on the selected endpoint.
- R10: Every bus access to the selected data port drops ready for another SETTLE cycles.
- R11: A new endpoint select written while the request bit is 1 is ignored.
- R12: Writes to the data port of an unselected endpoint store nothing and leave ready unchanged. Reads of such a port return 0.
- R13: A direction flip made before the settle period has elapsed commits no packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| usb_rst | input | 1 | USB bus reset, clears the control byte |
| bus_wr | input | 1 | register write strobe |
| bus_rd | input | 1 | register read strobe (advances data ports) |
| bus_addr | input | 3 | 0 = control byte, 4..7 = data ports of endpoints 0..3 |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data |
| rx_wr | input | 1 | received byte strobe |
| rx_ep | input | 2 | endpoint of received byte or packet end |
| rx_data | input | 8 | received byte |
| rx_done | input | 1 | end of received packet |
| rx_setup | input | 1 | the ending packet is a SETUP |
| tx_sel | input | 2 | endpoint viewed on the transmit side |
| tx_pkt_rdy | output | 1 | committed packet waiting on tx_sel |
| tx_len | output | $clog2(DEPTH+1) | byte count of that packet |
| tx_data | output | 8 | current byte of that packet |
| tx_pop | input | 1 | advance to the next transmit byte |
| tx_ack | input | 1 | packet sent, free the endpoint |

## Verification
The bench builds the block with DEPTH = 4 and SETTLE = 3. With these values the full buffer and the ready timing can be reached in a few cycles. It sweeps every endpoint against every packet length from 0 to 4, in both directions. This covers the empty packet, the full buffer, the setup and empty-packet flags, and the restart of the settle window after each byte. Directed sequences then cover flush, the locked select, unselected ports, early direction flips and USB reset.

// File: rtl/usb_ep_bridge.sv
module usb_ep_bridge #(
  parameter int DEPTH  = 8,
  parameter int SETTLE = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH),
  localparam int SW = $clog2(SETTLE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usb_rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          rx_wr,
  input  logic [1:0]    rx_ep,
  input  logic [7:0]    rx_data,
  input  logic          rx_done,
  input  logic          rx_setup,
  input  logic [1:0]    tx_sel,
  output logic          tx_pkt_rdy,
  output logic [CW-1:0] tx_len,
  output logic [7:0]    tx_data,
  input  logic          tx_pop,
  input  logic          tx_ack
);

  logic          req, txb, clr, scmd, len0;
  logic [1:0]    sel;
  logic          sess, sess_wr;
  logic [SW-1:0] scnt;
  logic [7:0]    mem [4][DEPTH];
  logic [3:0][CW-1:0] cnt, rptr;
  logic [3:0]    rxf, txp;

  logic settled, ctl_wr, port_hit, access, ready;
  logic req_rise, req_fall, end_edge, commit, release_pkt, do_clear;
  logic mcu_wr, mcu_rd, rx_ok, rx_push, rx_fin, set_scmd, set_len0;
  logic [7:0] ctl_q;

  assign settled   = scnt == SW'(SETTLE);
  assign ctl_wr    = bus_wr && bus_addr == 3'd0;
  assign port_hit  = bus_addr[2] && bus_addr[1:0] == sel;
  assign access    = (bus_wr || bus_rd) && port_hit;
  assign req_rise  = ctl_wr && !req && bus_wdata[0];
  assign req_fall  = ctl_wr && req && !bus_wdata[0];
  assign end_edge  = ctl_wr && req && bus_wdata[0] && sess && (bus_wdata[1] != txb);
  assign commit      = end_edge && settled && sess_wr;
  assign release_pkt = end_edge && settled && !sess_wr;
  assign do_clear  = req && clr;

  assign ready = req && sess && settled && !clr &&
                 (sess_wr ? (!rxf[sel] && !txp[sel] && cnt[sel] != CW'(DEPTH))
                          : (rxf[sel] && rptr[sel] != cnt[sel]));

  assign mcu_wr = bus_wr && port_hit && ready && sess_wr;
  assign mcu_rd = bus_rd && port_hit && ready && !sess_wr;

  assign rx_ok    = !rxf[rx_ep] && !txp[rx_ep] && !(req && sess && sess_wr && sel == rx_ep);
  assign rx_push  = rx_wr && rx_ok && cnt[rx_ep] != CW'(DEPTH);
  assign rx_fin   = rx_done && rx_ok;
  assign set_scmd = rx_fin && rx_setup && rx_ep == sel;
  assign set_len0 = rx_fin && cnt[rx_ep] == '0 && rx_ep == sel;

  assign ctl_q = {len0, ready, scmd, sel, clr, txb, req};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {req, txb, clr, scmd, len0, sel, sess, sess_wr} <= '0;
      scnt <= '0;
    end else if (usb_rst) begin
      {req, txb, clr, scmd, len0, sel, sess, sess_wr} <= '0;
      scnt <= '0;
    end else begin
      if (ctl_wr) begin
        req  <= bus_wdata[0];
        txb  <= bus_wdata[1];
        clr  <= bus_wdata[2];
        if (!req) sel <= bus_wdata[4:3];
        scmd <= (scmd & bus_wdata[5]) | set_scmd;
        len0 <= (len0 & bus_wdata[7]) | set_len0;
      end else begin
        scmd <= scmd | set_scmd;
        len0 <= len0 | set_len0;
      end
      if (req_rise) begin
        sess    <= 1'b1;
        sess_wr <= bus_wdata[1];
      end else if (req_fall || end_edge) begin
        sess <= 1'b0;
      end
      if (!req || access) scnt <= '0;
      else if (!settled)  scnt <= scnt + 1'b1;
    end
  end

  for (genvar e = 0; e < 4; e++) begin : g_ep
    logic [CW-1:0] c_q, r_q;
    logic          rf_q, tp_q, here, wipe, grow, adv;
    assign here = sel == 2'(e);
    assign wipe = (do_clear && here) || (release_pkt && here) ||
                  (tx_ack && tx_sel == 2'(e) && tp_q);
    assign grow = (mcu_wr && here) || (rx_push && rx_ep == 2'(e));
    assign adv  = (mcu_rd && here) ||
                  (tx_pop && tx_sel == 2'(e) && tp_q && r_q != c_q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= '0; r_q <= '0; rf_q <= 1'b0; tp_q <= 1'b0;
      end else if (wipe) begin
        c_q <= '0; r_q <= '0; rf_q <= 1'b0; tp_q <= 1'b0;
      end else begin
        if (grow) c_q <= c_q + 1'b1;
        if (adv)  r_q <= r_q + 1'b1;
        if (commit && here) tp_q <= 1'b1;
        if (rx_fin && rx_ep == 2'(e)) rf_q <= 1'b1;
      end
    end
    assign cnt[e]  = c_q;
    assign rptr[e] = r_q;
    assign rxf[e]  = rf_q;
    assign txp[e]  = tp_q;
  end

  always_ff @(posedge clk) begin
    if (mcu_wr)  mem[sel][cnt[sel][PW-1:0]]     <= bus_wdata;
    if (rx_push) mem[rx_ep][cnt[rx_ep][PW-1:0]] <= rx_data;
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == 3'd0) bus_rdata = ctl_q;
    else if (port_hit && rxf[sel]) bus_rdata = mem[sel][rptr[sel][PW-1:0]];
  end

  assign tx_pkt_rdy = txp[tx_sel];
  assign tx_len     = cnt[tx_sel];
  assign tx_data    = mem[tx_sel][rptr[tx_sel][PW-1:0]];

endmodule

// File: rtl/usb_ep_bridge_chk.sv
module usb_ep_bridge_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          usb_rst,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [2:0]    bus_addr,
  input logic [1:0]    sel,
  input logic          req,
  input logic          ready,
  input logic          scmd,
  input logic [7:0]    ctl_q,
  input logic [CW-1:0] tx_len
);

  a_r2_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> req);

  a_r10_access_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_addr[2] && bus_addr[1:0] == sel && ready && !usb_rst) |=> !ready);

  a_r1_usb_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    usb_rst |=> ctl_q == 8'h00);

  a_r8_scmd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (scmd && !usb_rst && !(bus_wr && bus_addr == 3'd0)) |=> scmd);

  a_r11_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !usb_rst) |=> $stable(sel));

  a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_len <= CW'(DEPTH));

endmodule

bind usb_ep_bridge usb_ep_bridge_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .usb_rst(usb_rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .sel(sel), .req(req), .ready(ready), .scmd(scmd),
  .ctl_q(ctl_q), .tx_len(tx_len)
);

// File: tb/usb_ep_bridge_tb_top.sv
module usb_ep_bridge_tb_top;
  localparam int DEPTH  = 4;
  localparam int SETTLE = 3;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [7:0] REQ = 8'h01, TX = 8'h02, CLR = 8'h04, RDY = 8'h40;

  logic clk = 1'b0, rst_n = 1'b0, usb_rst = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic rx_wr = 1'b0, rx_done = 1'b0, rx_setup = 1'b0;
  logic [1:0] rx_ep = '0, tx_sel = '0;
  logic [7:0] rx_data = '0, tx_data;
  logic tx_pkt_rdy, tx_pop = 1'b0, tx_ack = 1'b0;
  logic [CW-1:0] tx_len;

  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  usb_ep_bridge #(.DEPTH(DEPTH), .SETTLE(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .usb_rst(usb_rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_wr(rx_wr), .rx_ep(rx_ep), .rx_data(rx_data), .rx_done(rx_done), .rx_setup(rx_setup),
    .tx_sel(tx_sel), .tx_pkt_rdy(tx_pkt_rdy), .tx_len(tx_len), .tx_data(tx_data),
    .tx_pop(tx_pop), .tx_ack(tx_ack));

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic ctl(input logic [7:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic dwr(input int e, input logic [7:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'(4 + e); bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic drd(input int e, output logic [7:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 3'(4 + e); #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic peek(input int a, output logic [7:0] v);
    bus_addr = 3'(a); #1 v = bus_rdata;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic rx_byte(input int e, input logic [7:0] v);
    @(negedge clk); rx_wr = 1'b1; rx_ep = 2'(e); rx_data = v;
    @(negedge clk); rx_wr = 1'b0;
  endtask

  task automatic rx_end(input int e, input logic s);
    @(negedge clk); rx_done = 1'b1; rx_ep = 2'(e); rx_setup = s;
    @(negedge clk); rx_done = 1'b0; rx_setup = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [7:0] pat(int e, int n, int i);
    return 8'((e * 37 + n * 11 + i * 5 + 3) & 8'hff);
  endfunction

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 200000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<200000", cycles);
        summary();
      end
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(0, v); chk("R1 reset ctl", v, 0);
    for (int e = 0; e < 4; e++) begin
      tx_sel = 2'(e); #1 chk("R1 reset tx_pkt_rdy", tx_pkt_rdy, 0);
    end

    for (int e = 0; e < 4; e++) begin
      for (int n = 0; n <= DEPTH; n++) begin
        logic [7:0] s;
        s = 8'(e << 3);
        // write session sweep (R2 R5 R6 R10)
        ctl(TX | s); ctl(TX | REQ | s);
        for (int k = 0; k < SETTLE; k++) begin
          peek(0, v); chk("R2 ready before settle", v & RDY, 0);
          @(negedge clk);
        end
        peek(0, v); chk("R2 ready at settle", v & RDY, RDY);
        for (int i = 0; i < n; i++) begin
          dwr(e, pat(e, n, i));
          peek(0, v); chk("R10 ready low after access", v & RDY, 0);
          settle();
          peek(0, v); chk("R5 ready until full", v & RDY, (i + 1 < DEPTH) ? RDY : 0);
        end
        ctl(REQ | s); ctl(s);
        tx_sel = 2'(e); #1;
        chk(n == 0 ? "R6 zlp rdy" : "R5 pkt rdy", tx_pkt_rdy, 1);
        chk(n == 0 ? "R6 zlp len" : "R5 pkt len", tx_len, n);
        for (int i = 0; i < n; i++) begin
          chk("R5 tx byte", tx_data, pat(e, n, i));
          @(negedge clk); tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0; #1;
        end
        @(negedge clk); tx_ack = 1'b1; @(negedge clk); tx_ack = 1'b0;

        // read session sweep (R3 R4 R8 R9)
        ctl(s);
        for (int i = 0; i < n; i++) rx_byte(e, pat(e, n, i) ^ 8'h5a);
        rx_end(e, n == 2);
        repeat (2) @(negedge clk);
        peek(0, v);
        chk("R8 R9 flags", v, ((n == 0) ? 8'h80 : 0) | ((n == 2) ? 8'h20 : 0) | s);
        ctl(REQ | s); settle();
        for (int i = 0; i < n; i++) begin
          peek(0, v); chk("R3 ready with data", v & RDY, RDY);
          drd(e, v); chk("R3 rx byte", v, pat(e, n, i) ^ 8'h5a);
          settle();
        end
        peek(0, v); chk("R3 ready when drained", v & RDY, 0);
        ctl(TX | REQ | s); ctl(TX | s);
        ctl(TX | REQ | s); settle();
        peek(0, v); chk("R4 freed after release", v & RDY, RDY);
        ctl(TX | s); ctl(s);
      end
    end

    // R8: writing 1 does not set the setup flag
    ctl(8'h20); peek(0, v); chk("R8 write one no set", v & 8'h20, 0);

    // R7: flush a held packet
    ctl(8'h08);
    rx_byte(1, 8'h11); rx_byte(1, 8'h22); rx_byte(1, 8'h33); rx_end(1, 1'b0);
    ctl(REQ | CLR | 8'h08);
    peek(0, v); chk("R7 not ready during flush", v & RDY, 0);
    ctl(8'h08); ctl(TX | 8'h08); ctl(TX | REQ | 8'h08); settle();
    peek(0, v); chk("R7 endpoint emptied", v & RDY, RDY);
    ctl(TX | 8'h08); ctl(8'h08);

    // R11: select locked while request high
    ctl(REQ); ctl(REQ | 8'h18);
    peek(0, v); chk("R11 sel ignored", (v >> 3) & 3, 0);
    ctl(8'h00); ctl(8'h18);
    peek(0, v); chk("R11 sel taken when idle", (v >> 3) & 3, 3);
    ctl(8'h00);

    // R12: unselected data port
    ctl(TX); ctl(TX | REQ); settle();
    dwr(2, 8'h55);
    peek(0, v); chk("R12 ready unchanged", v & RDY, RDY);
    peek(6, v); chk("R12 unselected read", v, 0);
    ctl(REQ); ctl(8'h00);
    tx_sel = 2'd0; #1;
    chk("R12 ep0 len", tx_len, 0);
    tx_sel = 2'd2; #1;
    chk("R12 ep2 untouched", tx_pkt_rdy, 0);
    tx_sel = 2'd0;
    @(negedge clk); tx_ack = 1'b1; @(negedge clk); tx_ack = 1'b0;

    // R13: early direction flip commits nothing
    ctl(TX); ctl(TX | REQ); settle();
    dwr(0, 8'haa);
    ctl(REQ); ctl(8'h00);
    tx_sel = 2'd0; #1 chk("R13 no commit", tx_pkt_rdy, 0);
    ctl(REQ | CLR); ctl(8'h00);

    // R1: USB reset clears control byte
    ctl(TX | REQ | 8'h10);
    @(negedge clk); usb_rst = 1'b1; @(negedge clk); usb_rst = 1'b0;
    peek(0, v); chk("R1 usb reset ctl", v, 0);

    summary();
  end
endmodule